// File: doc/BRIEF.md
# External Interrupt Line Controller

This block gathers up to 32 asynchronous interrupt request pins from outside the chip and reduces them to one maskable interrupt and one non-maskable interrupt for the CPU. Each pin first passes through a two-stage synchroniser. A per-line sense circuit then detects one of four trigger conditions: high level, low level, rising edge or falling edge. A detected event is latched in a status bit. Software clears that bit by writing a one to it.

Software configures the block through a small synchronous register bus that uses word indices. Each line's interrupt enable is held in a mask. The mask is changed through separate write-one-to-set and write-one-to-clear registers, so one line can be changed without a read-modify-write. The general interrupt output is asserted while any latched event is also enabled. Line 0 can also drive a non-maskable output, which ignores the mask. Software can find the number of implemented lines by writing all ones to the sense-type register and reading it back.

Top module: `eic_ctrl`

## Requirements
- R1: After reset all registers hold zero. Every line is then disabled and set for falling-edge sensing, and `irq_o`, `nmi_o` and `rdata` are low.
- R2: A write to index 0 sets each mask bit whose data bit is 1. A write to index 1 clears each mask bit whose data bit is 1. Zero data bits leave the mask unchanged. Index 2 reads the mask.
- R3: A write to index 4 clears each latched status bit whose data bit is 1 and leaves the other bits unchanged. Index 3 reads the status.
- R4: When a line's bit in the sense-type register (index 5) is 1, the line is level sensed. Its bit in the polarity-level register (index 7) selects active-high (1) or active-low (0). The status bit is set again on every clock while the active level is present, so a clear does not stay in effect.
- R5: When a line's sense-type bit is 0, the line is edge sensed. Its bit in the polarity-edge register (index 6) selects rising (1) or falling (0). The status bit stays set until software clears it.
- R6: `irq_o` is high exactly when some status bit and the matching mask bit are both 1.
- R7: Register bits above `NUM_LINES-1` read as zero. After all ones are written to index 5, the index of the highest set bit read back, plus one, equals `NUM_LINES`.
- R8: Bit 0 of index 9 enables the non-maskable path. `nmi_o` equals status bit 0 while that enable is set and is low otherwise, whatever the mask holds.
- R9: When a new event and a status-clear write for the same line fall on the same clock, the status bit ends up set.
- R10: An input change first affects the status bit at the third rising clock edge after the change.
- R11: Read data is registered. It appears on `rdata` one clock after `rd_en`, and unmapped indices read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_i | input | NUM_LINES | Asynchronous external request pins |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register word index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Combined maskable interrupt |
| nmi_o | output | 1 | Non-maskable interrupt from line 0 |

## Verification
The assertions assume that status bits are cleared only by bus writes to index 4 and that the mask changes only through writes to indices 0 and 1. They also assume the bus never issues a write and a read of the same register at the same time. The stimulus drives one bus operation per task call, with its strobe held for a single cycle. It holds the external pins stable for several cycles before each check, so that every synchronised value has settled before the expected status is computed. The test mixes random line configurations and pin patterns with directed checks of the clear-versus-event collision and of the exact three-edge latency.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    IDX_EN_SET   = 4'd0,
    IDX_EN_CLR   = 4'd1,
    IDX_MASK     = 4'd2,
    IDX_STAT     = 4'd3,
    IDX_STAT_CLR = 4'd4,
    IDX_MODE     = 4'd5,
    IDX_EDGE     = 4'd6,
    IDX_LEVEL    = 4'd7,
    IDX_NMI      = 4'd9
  } reg_idx_e;
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  for (genvar i = 0; i < W; i++) begin : g_line
    logic st1, st2, st3;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st1 <= 1'b0;
        st2 <= 1'b0;
        st3 <= 1'b0;
      end else begin
        st1 <= async_i[i];
        st2 <= st1;
        st3 <= st2;
      end
    end
    assign cur_o[i]  = st2;
    assign prev_o[i] = st3;
  end
endmodule

// File: rtl/eic_sense.sv
module eic_sense #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] mode_i,
  input  logic [W-1:0] edge_i,
  input  logic [W-1:0] level_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o
);
  for (genvar i = 0; i < W; i++) begin : g_line
    logic lvl_hit, rise, fall, edg_hit, hit, st_q;
    always_comb begin
      lvl_hit = (cur_i[i] == level_i[i]);
      rise    = cur_i[i] & ~prev_i[i];
      fall    = ~cur_i[i] & prev_i[i];
      edg_hit = edge_i[i] ? rise : fall;
      hit     = mode_i[i] ? lvl_hit : edg_hit;
    end
    always_ff @(posedge clk) begin
      if (!rst_n) st_q <= 1'b0;
      else        st_q <= hit | (st_q & ~clr_i[i]);
    end
    assign status_o[i] = st_q;
  end
endmodule

// File: rtl/eic_regs.sv
module eic_regs
  import eic_pkg::*;
#(
  parameter int W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [W-1:0]      status_i,
  output logic [W-1:0]      mask_o,
  output logic [W-1:0]      mode_o,
  output logic [W-1:0]      edge_o,
  output logic [W-1:0]      level_o,
  output logic              nmi_en_o,
  output logic [W-1:0]      clr_o,
  output logic [DATA_W-1:0] rdata
);
  function automatic logic [DATA_W-1:0] widen(input logic [W-1:0] v);
    logic [DATA_W-1:0] r;
    r = '0;
    r[W-1:0] = v;
    return r;
  endfunction

  logic [W-1:0] wbits;
  assign wbits = wdata[W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_o   <= '0;
      mode_o   <= '0;
      edge_o   <= '0;
      level_o  <= '0;
      nmi_en_o <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        IDX_EN_SET: mask_o   <= mask_o | wbits;
        IDX_EN_CLR: mask_o   <= mask_o & ~wbits;
        IDX_MODE:   mode_o   <= wbits;
        IDX_EDGE:   edge_o   <= wbits;
        IDX_LEVEL:  level_o  <= wbits;
        IDX_NMI:    nmi_en_o <= wdata[0];
        default: ;
      endcase
    end
  end

  assign clr_o = (wr_en && addr == IDX_STAT_CLR) ? wbits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        IDX_MASK:  rdata <= widen(mask_o);
        IDX_STAT:  rdata <= widen(status_i);
        IDX_MODE:  rdata <= widen(mode_o);
        IDX_EDGE:  rdata <= widen(edge_o);
        IDX_LEVEL: rdata <= widen(level_o);
        IDX_NMI:   rdata <= {{(DATA_W-1){1'b0}}, nmi_en_o};
        default:   rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/eic_ctrl.sv
module eic_ctrl
  import eic_pkg::*;
#(
  parameter int NUM_LINES = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] ext_i,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [3:0]           addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic                 irq_o,
  output logic                 nmi_o
);
  logic [NUM_LINES-1:0] cur, prev, mask, mode, edgep, levelp, clr, status;
  logic                 nmi_en;

  eic_sync #(.W(NUM_LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(ext_i), .cur_o(cur), .prev_o(prev)
  );

  eic_sense #(.W(NUM_LINES)) u_sense (
    .clk(clk), .rst_n(rst_n), .cur_i(cur), .prev_i(prev), .mode_i(mode),
    .edge_i(edgep), .level_i(levelp), .clr_i(clr), .status_o(status)
  );

  eic_regs #(.W(NUM_LINES)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .status_i(status), .mask_o(mask), .mode_o(mode),
    .edge_o(edgep), .level_o(levelp), .nmi_en_o(nmi_en), .clr_o(clr),
    .rdata(rdata)
  );

  assign irq_o = |(status & mask);
  assign nmi_o = nmi_en & status[0];
endmodule

// File: rtl/eic_ctrl_chk.sv
module eic_ctrl_chk #(
  parameter int NUM_LINES = 20
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [3:0]           addr,
  input logic [NUM_LINES-1:0] mask,
  input logic [NUM_LINES-1:0] status,
  input logic                 nmi_en,
  input logic                 irq_o,
  input logic                 nmi_o
);
  // R6: interrupt only with an enabled latched event
  p_irq_needs_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((status & mask) != '0));

  // R8: non-maskable output only with enable and line 0 latched
  p_nmi_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_o |-> (nmi_en && status[0]));

  // R3: a latched bit falls only after a status-clear write
  p_status_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(status) & ~status) != '0) |-> $past(wr_en && addr == 4'd4));

  // R2: the mask moves only after a set or clear write
  p_mask_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mask) |-> $past(wr_en && (addr == 4'd0 || addr == 4'd1)));
endmodule

bind eic_ctrl eic_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .mask(mask),
  .status(status), .nmi_en(nmi_en), .irq_o(irq_o), .nmi_o(nmi_o)
);

// File: tb/sim_eic_ctrl.sv
`timescale 1ns/1ps
module sim_eic_ctrl;
  localparam int LINES = 20;
  localparam logic [31:0] ALL = (32'h1 << LINES) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [LINES-1:0] ext_i = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq_o, nmi_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  eic_ctrl #(.NUM_LINES(LINES)) u0 (
    .clk(clk), .rst_n(rst_n), .ext_i(ext_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .nmi_o(nmi_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(posedge clk); #1;
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Expected status from configuration and two settled pin patterns
  function automatic logic [31:0] exp_status(input logic [31:0] md, input logic [31:0] ed,
      input logic [31:0] lv, input logic [31:0] v0, input logic [31:0] v1);
    logic [31:0] r = '0;
    for (int i = 0; i < LINES; i++) begin
      if (md[i]) r[i] = (v0[i] == lv[i]) || (v1[i] == lv[i]);
      else if (ed[i]) r[i] = !v0[i] && v1[i];
      else r[i] = v0[i] && !v1[i];
    end
    return r;
  endfunction

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, md, ed, lv, m, v0, v1, e;
    logic en;
    int top;
    void'($urandom(32'd1234));
    cyc(3); rst_n = 1'b1; cyc(1);

    // R1 reset state
    chk("R1 irq", {31'b0, irq_o}, 0);
    chk("R1 nmi", {31'b0, nmi_o}, 0);
    chk("R1 rdata", rdata, 0);
    rd(4'd2, d); chk("R1 mask", d, 0);
    rd(4'd5, d); chk("R1 mode", d, 0);
    rd(4'd3, d); chk("R1 status", d, 0);

    // R7 probe of implemented lines
    wr(4'd5, 32'hFFFF_FFFF);
    rd(4'd5, d); chk("R7 mode readback", d, ALL);
    top = 0;
    for (int i = 0; i < 32; i++) if (d[i]) top = i + 1;
    chk("R7 line count", top, LINES);
    wr(4'd5, 0);

    // R2 mask set / clear
    wr(4'd0, 32'h0000_000F); wr(4'd1, 32'h0000_0005);
    rd(4'd2, d); chk("R2 mask set/clr", d, 32'h0000_000A);
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd2, d); chk("R7 mask upper zero", d, ALL);
    wr(4'd1, 32'hFFFF_FFFF);

    // R11 unmapped read and read latency
    rd(4'd8, d); chk("R11 unmapped", d, 0);
    wr(4'd9, 1);
    rd_en = 1'b1; addr = 4'd9; #0.5;
    chk("R11 before edge", rdata, 0);
    @(posedge clk); #1; rd_en = 1'b0;
    chk("R11 after edge", rdata, 1);
    wr(4'd9, 0);

    // R10 latency: line 4 falling edge, mask bit 4
    wr(4'd0, 32'h10);
    ext_i[4] = 1'b1; cyc(5); wr(4'd4, ALL);
    ext_i[4] = 1'b0;
    cyc(2); chk("R10 not yet", {31'b0, irq_o}, 0);
    cyc(1); chk("R10 third edge", {31'b0, irq_o}, 1);
    cyc(3); chk("R5 sticky", {31'b0, irq_o}, 1);
    wr(4'd4, 32'h10); cyc(1);
    chk("R3 cleared", {31'b0, irq_o}, 0);
    wr(4'd1, ALL);

    // R9 event and clear on the same edge: line 3 rising
    wr(4'd6, 32'h8);
    ext_i[3] = 1'b1;
    @(posedge clk); @(posedge clk);
    wr(4'd4, 32'h8);
    rd(4'd3, d); chk("R9 event wins", d & 32'h8, 32'h8);
    wr(4'd4, 32'h8);
    rd(4'd3, d); chk("R3 later clear", d & 32'h8, 0);

    // R4 level-high hold: line 3 level high, held high
    wr(4'd5, 32'h8); wr(4'd7, 32'h8); cyc(2);
    wr(4'd4, 32'h8);
    rd(4'd3, d); chk("R4 level reasserts", d & 32'h8, 32'h8);
    ext_i[3] = 1'b0; cyc(4); wr(4'd4, 32'h8); cyc(2);
    rd(4'd3, d); chk("R4 inactive clears", d & 32'h8, 0);

    // R8 nmi independent of mask: line 0 rising, mask zero
    wr(4'd5, 0); wr(4'd7, 0); wr(4'd6, 32'h1); wr(4'd4, ALL);
    wr(4'd9, 1);
    ext_i[0] = 1'b1; cyc(4);
    chk("R8 nmi on", {31'b0, nmi_o}, 1);
    chk("R6 masked irq", {31'b0, irq_o}, 0);
    wr(4'd9, 0); cyc(1);
    chk("R8 nmi off", {31'b0, nmi_o}, 0);
    ext_i = '0; cyc(4); wr(4'd4, ALL);

    // Random configurations and pin patterns
    for (int it = 0; it < 60; it++) begin
      md = $urandom() & ALL; ed = $urandom() & ALL; lv = $urandom() & ALL;
      m = $urandom() & ALL; en = 1'($urandom());
      v0 = $urandom() & ALL; v1 = $urandom() & ALL;
      wr(4'd5, md); wr(4'd6, ed); wr(4'd7, lv);
      wr(4'd1, ALL); wr(4'd0, m); wr(4'd9, {31'b0, en});
      ext_i = v0[LINES-1:0]; cyc(6);
      wr(4'd4, ALL);
      ext_i = v1[LINES-1:0]; cyc(6);
      e = exp_status(md, ed, lv, v0, v1);
      rd(4'd3, d); chk("R4/R5 random status", d, e);
      rd(4'd2, d); chk("R2 random mask", d, m);
      chk("R6 random irq", {31'b0, irq_o}, {31'b0, |(e & m)});
      chk("R8 random nmi", {31'b0, nmi_o}, {31'b0, en & e[0]});
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule